// File: doc/BRIEF.md
# Raster Timing Generator with Early Fetch Pulse

This block generates the raster timing for a display link that is driven in video mode. Geometry arrives per axis as four numbers: the active size, the position where sync starts, the position where sync ends, and the total. The block derives the sync width and both porches from these values and checks that they are consistent. It then produces horizontal and vertical sync, a data-enable window, the pixel and line position inside the active area, and a line counter readout. It also emits a single-cycle pulse that tells the upstream pixel fetch to start a set number of lines before the next frame. That number of lines is chosen from a worst-case fetch requirement `FETCH_WC_LINES`.

Pixels arrive on a valid/ready stream. The block asserts `s_ready` in every active cycle and in no other cycle, and a beat transfers when `s_valid` and `s_ready` are both high. The block never waits for the upstream source. If no beat is offered in an active cycle, the slot is filled with the underflow colour, the beat is lost, and `underrun` pulses.

The link kind changes how the geometry is interpreted. A DSI-type link always uses active-high syncs. On DisplayPort-type links the front porch is moved into the back porch, so the active region ends each line and each frame. A split option halves the horizontal geometry for a link that drives half of a panel.

Top module: `raster_timing_gen`

## Requirements
- R1: A line lasts `total` cycles. Columns are counted from 0 at the start of hsync. The line is, in order: sync (`sync_end - sync_start` cycles), back porch (`total - sync_end`), active (`active`), and front porch (`sync_start - active`). Frames are built the same way from lines, with vsync covering the first lines. `de` is high exactly when both the column and the line are in their active parts.
- R2: Each sync output is active-high when its `neg_*` request is 0 and active-low when it is 1. While the block is not running, each sync sits at its deasserted level.
- R3: When `link_kind` is 1 (DSI-type), both syncs are active-high whatever `neg_hsync` and `neg_vsync` request.
- R4: When `link_kind` is 2 or 3 (DisplayPort-type), on both axes the front porch is added to the back porch and the front porch becomes zero.
- R5: The geometry is rejected if, on either axis, the active size is zero, sync start is below active, sync end is below sync start, or total is below sync end. When the geometry is rejected, timing stays off: `de`, `line_cnt` and `fetch_pulse` stay 0 and the syncs stay deasserted.
- R6: Let `sof` be the vertical sync width plus the vertical back porch, measured after R4 is applied. The fetch line count is 0 if `sof >= FETCH_WC_LINES`. Otherwise it is the whole vertical front porch if that porch is below `FETCH_WC_LINES - sof`. Otherwise it is `FETCH_WC_LINES - sof`.
- R7: A frame pixel counter is 1 in the first cycle of each frame and increments each cycle. `fetch_pulse` is high for one cycle when this counter equals `(vtotal - fetch_lines) * htotal + 1`. It never fires when the fetch line count is 0.
- R8: When `split_half` is 1, the horizontal active, sync start, sync end and total are each shifted right by one bit before R1, R4, R5 and R6 are applied.
- R9: A rising edge of `enable` captures all configuration inputs. In the next cycle, timing starts at column 0, line 0. Configuration changes while running have no effect, and a rising edge during a frame restarts it.
- R10: When `enable` falls, the current frame runs to its last cycle, and then all outputs stay idle with `line_cnt` at 0.
- R11: `s_ready` equals `de`. During `de`, `pix_out` carries `s_data` if `s_valid` is high, and the underflow colour (every byte 0xFF) otherwise. Outside `de`, `pix_out` carries the border colour 0.
- R12: `underrun` is high in exactly the cycles where `de` is high and `s_valid` is low.
- R13: `line_cnt` reports the current line index from 0. During `de`, `pos_x` and `pos_y` give the offset from the first active column and the first active line. They are 0 outside `de`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Rising edge captures the configuration and starts timing; low stops at frame end |
| split_half | input | 1 | Halve the horizontal geometry |
| link_kind | input | 2 | 0 generic, 1 DSI-type, 2/3 DisplayPort-type |
| neg_hsync | input | 1 | Request active-low hsync |
| neg_vsync | input | 1 | Request active-low vsync |
| h_active | input | DIM_W | Active pixels per line |
| h_sync_start | input | DIM_W | Horizontal sync start position |
| h_sync_end | input | DIM_W | Horizontal sync end position |
| h_total | input | DIM_W | Cycles per line |
| v_active | input | DIM_W | Active lines per frame |
| v_sync_start | input | DIM_W | Vertical sync start line |
| v_sync_end | input | DIM_W | Vertical sync end line |
| v_total | input | DIM_W | Lines per frame |
| s_valid | input | 1 | Pixel beat offered |
| s_ready | output | 1 | Pixel beat accepted (active cycles) |
| s_data | input | PIX_W | Pixel beat data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | PIX_W | Output pixel, underflow or border colour |
| pos_x | output | DIM_W | Active column |
| pos_y | output | DIM_W | Active line |
| line_cnt | output | DIM_W | Current line index |
| fetch_pulse | output | 1 | Early fetch start pulse |
| underrun | output | 1 | Active cycle without offered data |

## Verification
The hardest situations to reach from the ports are the ones that depend on when `enable` moves relative to frame boundaries. One is dropping `enable` partway through a frame and confirming the block still finishes that frame before going idle. Another is raising `enable` again mid-frame so the frame restarts. A third is changing the geometry inputs while running and confirming they are ignored. The stimulus reaches these by holding `enable` across frame boundaries in directed sequences. It also uses a small worst-case fetch requirement, so short random frames land in each of the three fetch-line branches, and random link kinds and split settings, including cases that fold or halve into rejected geometry.

// File: rtl/raster_pkg.sv
package raster_pkg;
  typedef enum logic [1:0] {
    LINK_GENERIC = 2'd0,
    LINK_DSI     = 2'd1,
    LINK_DP      = 2'd2,
    LINK_EDP     = 2'd3
  } link_kind_e;

  // packet-style links carry no front porch of their own
  function automatic logic folds_porch(link_kind_e k);
    return (k == LINK_DP) || (k == LINK_EDP);
  endfunction

  // command-style serial links only accept active-high syncs
  function automatic logic forces_high_sync(link_kind_e k);
    return k == LINK_DSI;
  endfunction
endpackage

// File: rtl/raster_axis_derive.sv
module raster_axis_derive #(
  parameter int unsigned DIM_W = 12
) (
  input  logic [DIM_W-1:0] act,
  input  logic [DIM_W-1:0] sync_start,
  input  logic [DIM_W-1:0] sync_end,
  input  logic [DIM_W-1:0] total,
  input  logic             halve,
  input  logic             fold,
  output logic [DIM_W-1:0] sync_w,
  output logic [DIM_W-1:0] porch_back,
  output logic [DIM_W-1:0] porch_front,
  output logic [DIM_W-1:0] span,
  output logic             geom_ok
);
  logic [DIM_W-1:0] a, s, e, t;

  always_comb begin
    a = halve ? (act >> 1)        : act;
    s = halve ? (sync_start >> 1) : sync_start;
    e = halve ? (sync_end >> 1)   : sync_end;
    t = halve ? (total >> 1)      : total;
    geom_ok = (a != '0) && (s >= a) && (e >= s) && (t >= e);
    sync_w  = e - s;
    span    = t;
    if (fold) begin
      porch_back  = (t - e) + (s - a);
      porch_front = '0;
    end else begin
      porch_back  = t - e;
      porch_front = s - a;
    end
  end
endmodule

// File: rtl/raster_fetch_plan.sv
module raster_fetch_plan #(
  parameter int unsigned DIM_W          = 12,
  parameter int unsigned CNT_W          = 24,
  parameter int unsigned FETCH_WC_LINES = 8
) (
  input  logic [DIM_W-1:0] vsw,
  input  logic [DIM_W-1:0] vbp,
  input  logic [DIM_W-1:0] vfp,
  input  logic [DIM_W-1:0] vtot,
  input  logic [DIM_W-1:0] htot,
  output logic             fetch_en,
  output logic [CNT_W-1:0] fetch_at
);
  localparam int unsigned SOF_W = DIM_W + 1;
  localparam logic [SOF_W-1:0] WC = SOF_W'(FETCH_WC_LINES);

  logic [SOF_W-1:0] sof, need;
  logic [DIM_W-1:0] lines;

  always_comb begin
    sof  = {1'b0, vsw} + {1'b0, vbp};
    need = WC - sof;
    if (sof >= WC)
      lines = '0;
    else if ({1'b0, vfp} < need)
      lines = vfp;
    else
      lines = need[DIM_W-1:0];
    fetch_en = (lines != '0);
    fetch_at = (CNT_W'(vtot - lines) * CNT_W'(htot)) + CNT_W'(1);
  end
endmodule

// File: rtl/raster_scan.sv
module raster_scan #(
  parameter int unsigned DIM_W = 12,
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_ok,
  input  logic             keep_on,
  input  logic [DIM_W-1:0] htot,
  input  logic [DIM_W-1:0] vtot,
  output logic             run,
  output logic [DIM_W-1:0] h_cnt,
  output logic [DIM_W-1:0] v_cnt,
  output logic [CNT_W-1:0] pix_cnt
);
  logic h_last, v_last;
  assign h_last = (h_cnt == htot - 1'b1);
  assign v_last = (v_cnt == vtot - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      h_cnt   <= '0;
      v_cnt   <= '0;
      pix_cnt <= '0;
    end else if (start) begin
      run     <= start_ok;
      h_cnt   <= '0;
      v_cnt   <= '0;
      pix_cnt <= CNT_W'(1);
    end else if (run) begin
      if (h_last) begin
        h_cnt <= '0;
        if (v_last) begin
          v_cnt   <= '0;
          pix_cnt <= CNT_W'(1);
          run     <= keep_on;
        end else begin
          v_cnt   <= v_cnt + 1'b1;
          pix_cnt <= pix_cnt + 1'b1;
        end
      end else begin
        h_cnt   <= h_cnt + 1'b1;
        pix_cnt <= pix_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned DIM_W          = 12,
  parameter int unsigned PIX_W          = 24,
  parameter int unsigned FETCH_WC_LINES = 8,
  parameter logic [7:0]  UFLOW_BYTE     = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             split_half,
  input  logic [1:0]       link_kind,
  input  logic             neg_hsync,
  input  logic             neg_vsync,
  input  logic [DIM_W-1:0] h_active,
  input  logic [DIM_W-1:0] h_sync_start,
  input  logic [DIM_W-1:0] h_sync_end,
  input  logic [DIM_W-1:0] h_total,
  input  logic [DIM_W-1:0] v_active,
  input  logic [DIM_W-1:0] v_sync_start,
  input  logic [DIM_W-1:0] v_sync_end,
  input  logic [DIM_W-1:0] v_total,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix_out,
  output logic [DIM_W-1:0] pos_x,
  output logic [DIM_W-1:0] pos_y,
  output logic [DIM_W-1:0] line_cnt,
  output logic             fetch_pulse,
  output logic             underrun
);
  localparam int unsigned CNT_W = 2 * DIM_W;
  localparam int unsigned N_AX  = 2;   // 0 horizontal, 1 vertical
  localparam logic [PIX_W-1:0] UFLOW_PIX  = {(PIX_W/8){UFLOW_BYTE}};
  localparam logic [PIX_W-1:0] BORDER_PIX = '0;

  link_kind_e kind;
  logic       fold, start, en_q;
  assign kind  = link_kind_e'(link_kind);
  assign fold  = folds_porch(kind);
  assign start = enable & ~en_q;

  // ---- geometry derivation per axis ----
  logic [DIM_W-1:0] raw_act [N_AX];
  logic [DIM_W-1:0] raw_ss  [N_AX];
  logic [DIM_W-1:0] raw_se  [N_AX];
  logic [DIM_W-1:0] raw_tot [N_AX];
  logic [DIM_W-1:0] d_sw    [N_AX];
  logic [DIM_W-1:0] d_bp    [N_AX];
  logic [DIM_W-1:0] d_fp    [N_AX];
  logic [DIM_W-1:0] d_tot   [N_AX];
  logic             d_ok    [N_AX];

  assign raw_act[0] = h_active;  assign raw_act[1] = v_active;
  assign raw_ss[0]  = h_sync_start; assign raw_ss[1] = v_sync_start;
  assign raw_se[0]  = h_sync_end;   assign raw_se[1] = v_sync_end;
  assign raw_tot[0] = h_total;   assign raw_tot[1] = v_total;

  for (genvar ax = 0; ax < N_AX; ax++) begin : g_axis
    raster_axis_derive #(.DIM_W(DIM_W)) i_axis (
      .act        (raw_act[ax]),
      .sync_start (raw_ss[ax]),
      .sync_end   (raw_se[ax]),
      .total      (raw_tot[ax]),
      .halve      ((ax == 0) && split_half),
      .fold       (fold),
      .sync_w     (d_sw[ax]),
      .porch_back (d_bp[ax]),
      .porch_front(d_fp[ax]),
      .span       (d_tot[ax]),
      .geom_ok    (d_ok[ax])
    );
  end

  logic             f_en;
  logic [CNT_W-1:0] f_at;
  raster_fetch_plan #(.DIM_W(DIM_W), .CNT_W(CNT_W), .FETCH_WC_LINES(FETCH_WC_LINES)) i_fetch (
    .vsw(d_sw[1]), .vbp(d_bp[1]), .vfp(d_fp[1]), .vtot(d_tot[1]), .htot(d_tot[0]),
    .fetch_en(f_en), .fetch_at(f_at)
  );

  // ---- configuration captured on the enable rising edge ----
  logic [DIM_W-1:0] r_hsw, r_hbp, r_hfp, r_ht, r_vsw, r_vbp, r_vfp, r_vt;
  logic             r_hneg, r_vneg, r_fen;
  logic [CNT_W-1:0] r_fat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      r_hsw <= '0; r_hbp <= '0; r_hfp <= '0; r_ht <= '0;
      r_vsw <= '0; r_vbp <= '0; r_vfp <= '0; r_vt <= '0;
      r_hneg <= 1'b0; r_vneg <= 1'b0; r_fen <= 1'b0; r_fat <= '0;
    end else begin
      en_q <= enable;
      if (start) begin
        r_hsw <= d_sw[0]; r_hbp <= d_bp[0]; r_hfp <= d_fp[0]; r_ht <= d_tot[0];
        r_vsw <= d_sw[1]; r_vbp <= d_bp[1]; r_vfp <= d_fp[1]; r_vt <= d_tot[1];
        r_hneg <= neg_hsync & ~forces_high_sync(kind);
        r_vneg <= neg_vsync & ~forces_high_sync(kind);
        r_fen  <= f_en;
        r_fat  <= f_at;
      end
    end
  end

  // ---- scan counters ----
  logic             run;
  logic [DIM_W-1:0] h_cnt, v_cnt;
  logic [CNT_W-1:0] pix_cnt;

  raster_scan #(.DIM_W(DIM_W), .CNT_W(CNT_W)) i_scan (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ok(d_ok[0] & d_ok[1]),
    .keep_on(enable), .htot(r_ht), .vtot(r_vt),
    .run(run), .h_cnt(h_cnt), .v_cnt(v_cnt), .pix_cnt(pix_cnt)
  );

  // ---- output decode ----
  logic [DIM_W-1:0] h_lo, h_hi, v_lo, v_hi;
  logic             in_h, in_v;
  assign h_lo = r_hsw + r_hbp;
  assign h_hi = r_ht - r_hfp;
  assign v_lo = r_vsw + r_vbp;
  assign v_hi = r_vt - r_vfp;
  assign in_h = (h_cnt >= h_lo) && (h_cnt < h_hi);
  assign in_v = (v_cnt >= v_lo) && (v_cnt < v_hi);

  assign de          = run & in_h & in_v;
  assign hsync       = (run & (h_cnt < r_hsw)) ^ r_hneg;
  assign vsync       = (run & (v_cnt < r_vsw)) ^ r_vneg;
  assign pos_x       = de ? (h_cnt - h_lo) : '0;
  assign pos_y       = de ? (v_cnt - v_lo) : '0;
  assign line_cnt    = v_cnt;
  assign fetch_pulse = run & r_fen & (pix_cnt == r_fat);

  assign s_ready  = de;
  assign underrun = de & ~s_valid;
  assign pix_out  = !de ? BORDER_PIX : (s_valid ? s_data : UFLOW_PIX);
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int unsigned DIM_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             run,
  input logic [DIM_W-1:0] h,
  input logic [DIM_W-1:0] v,
  input logic [DIM_W-1:0] ht,
  input logic [DIM_W-1:0] vt,
  input logic [DIM_W-1:0] hsw,
  input logic             de,
  input logic [DIM_W-1:0] pos_x,
  input logic             fetch_pulse,
  input logic [DIM_W-1:0] line_cnt
);
  // R1: active window never overlaps the hsync pulse
  a_r1_de_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (h >= hsw));

  // R5: nothing is emitted while timing is off
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!de && !fetch_pulse));

  // R7: the fetch pulse lasts a single cycle
  a_r7_fetch_single: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_pulse |=> !fetch_pulse);

  // R10: timing only stops on the last cycle of a frame (or a rejected start)
  a_r10_stop_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> ($past(start) || (($past(h) == $past(ht) - 1'b1) && ($past(v) == $past(vt) - 1'b1))));

  // R13: the line counter steps by one or wraps to zero
  a_r13_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(start) && (line_cnt != $past(line_cnt)))
      |-> ((line_cnt == DIM_W'($past(line_cnt) + 1'b1)) || (line_cnt == '0)));

  // R13: column position advances by one inside an active run
  a_r13_posx_step: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && !$past(start)) |-> ((pos_x == DIM_W'($past(pos_x) + 1'b1)) || (pos_x == '0)));
endmodule

bind raster_timing_gen raster_timing_chk #(.DIM_W(DIM_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .run(run), .h(h_cnt), .v(v_cnt),
  .ht(r_ht), .vt(r_vt), .hsw(r_hsw), .de(de), .pos_x(pos_x),
  .fetch_pulse(fetch_pulse), .line_cnt(line_cnt)
);

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  localparam int WC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, split_half = 1'b0, neg_hsync = 1'b0, neg_vsync = 1'b0;
  logic [1:0]  link_kind = 2'd0;
  logic [11:0] h_active = '0, h_sync_start = '0, h_sync_end = '0, h_total = '0;
  logic [11:0] v_active = '0, v_sync_start = '0, v_sync_end = '0, v_total = '0;
  logic        s_valid = 1'b0, s_ready;
  logic [23:0] s_data = '0, pix_out;
  logic        hsync, vsync, de, fetch_pulse, underrun;
  logic [11:0] pos_x, pos_y, line_cnt;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  raster_timing_gen #(.DIM_W(12), .PIX_W(24), .FETCH_WC_LINES(WC)) i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable), .split_half(split_half), .link_kind(link_kind),
    .neg_hsync(neg_hsync), .neg_vsync(neg_vsync),
    .h_active(h_active), .h_sync_start(h_sync_start), .h_sync_end(h_sync_end), .h_total(h_total),
    .v_active(v_active), .v_sync_start(v_sync_start), .v_sync_end(v_sync_end), .v_total(v_total),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_out(pix_out), .pos_x(pos_x), .pos_y(pos_y),
    .line_cnt(line_cnt), .fetch_pulse(fetch_pulse), .underrun(underrun)
  );

  typedef struct {
    int hsw, hbp, hfp, ht, vsw, vbp, vfp, vt, fl;
    bit ok, hn, vn;
  } exp_t;
  exp_t cur;

  function automatic exp_t expect_of(int ha, int hss, int hse, int ht, int va, int vss, int vse, int vt,
                                     bit sp, int kind, bit nh, bit nv);
    exp_t e;
    int sof;
    if (sp) begin ha = ha >> 1; hss = hss >> 1; hse = hse >> 1; ht = ht >> 1; end
    e.ok = (ha > 0) && (hss >= ha) && (hse >= hss) && (ht >= hse) &&
           (va > 0) && (vss >= va) && (vse >= vss) && (vt >= vse);
    e.hsw = hse - hss; e.hbp = ht - hse; e.hfp = hss - ha; e.ht = ht;
    e.vsw = vse - vss; e.vbp = vt - vse; e.vfp = vss - va; e.vt = vt;
    if (kind >= 2) begin
      e.hbp += e.hfp; e.hfp = 0;
      e.vbp += e.vfp; e.vfp = 0;
    end
    sof = e.vsw + e.vbp;
    if (sof >= WC) e.fl = 0;
    else if (e.vfp < WC - sof) e.fl = e.vfp;
    else e.fl = WC - sof;
    e.hn = (kind == 1) ? 1'b0 : nh;
    e.vn = (kind == 1) ? 1'b0 : nv;
    return e;
  endfunction

  task automatic set_mode(int ha, int hss, int hse, int ht, int va, int vss, int vse, int vt,
                          bit sp, int kind, bit nh, bit nv, bit update_exp);
    h_active = 12'(ha); h_sync_start = 12'(hss); h_sync_end = 12'(hse); h_total = 12'(ht);
    v_active = 12'(va); v_sync_start = 12'(vss); v_sync_end = 12'(vse); v_total = 12'(vt);
    split_half = sp; link_kind = 2'(kind); neg_hsync = nh; neg_vsync = nv;
    if (update_exp) cur = expect_of(ha, hss, hse, ht, va, vss, vse, vt, sp, kind, nh, nv);
  endtask

  task automatic check(bit good, string what, int act, int exp);
    n_tests++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic check_cycle(int f, string scen, bit live);
    int h, v, hlo, vlo, ex_x, ex_y;
    bit e_de, e_hs, e_vs, e_fp;
    logic [23:0] e_pix;
    h = live ? f % cur.ht : 0;
    v = live ? f / cur.ht : 0;
    hlo = cur.hsw + cur.hbp;
    vlo = cur.vsw + cur.vbp;
    e_de = live && h >= hlo && h < cur.ht - cur.hfp && v >= vlo && v < cur.vt - cur.vfp;
    e_hs = (live && h < cur.hsw) ^ cur.hn;
    e_vs = (live && v < cur.vsw) ^ cur.vn;
    e_fp = live && cur.fl != 0 && f == (cur.vt - cur.fl) * cur.ht;
    ex_x = e_de ? h - hlo : 0;
    ex_y = e_de ? v - vlo : 0;
    e_pix = !e_de ? 24'h0 : (s_valid ? s_data : 24'hFFFFFF);
    check(de == e_de, {scen, " R1 de"}, int'(de), int'(e_de));
    check(hsync == e_hs, {scen, " R2 hsync"}, int'(hsync), int'(e_hs));
    check(vsync == e_vs, {scen, " R2 vsync"}, int'(vsync), int'(e_vs));
    check(fetch_pulse == e_fp, {scen, " R7 fetch"}, int'(fetch_pulse), int'(e_fp));
    check(int'(line_cnt) == v, {scen, " R13 line"}, int'(line_cnt), v);
    check(int'(pos_x) == ex_x && int'(pos_y) == ex_y, {scen, " R13 pos"},
          int'(pos_x) * 4096 + int'(pos_y), ex_x * 4096 + ex_y);
    check(s_ready == e_de, {scen, " R11 ready"}, int'(s_ready), int'(e_de));
    check(pix_out == e_pix, {scen, " R11 pixel"}, int'(pix_out), int'(e_pix));
    check(underrun == (e_de && !s_valid), {scen, " R12 underrun"}, int'(underrun), int'(e_de && !s_valid));
  endtask

  task automatic play(string scen, int nframes, bit restart, bit drop);
    int flen;
    flen = cur.ok ? cur.ht * cur.vt : 40;
    if (restart) begin
      enable = 1'b0; @(negedge clk);
      enable = 1'b1; @(negedge clk);
    end
    for (int k = 0; k < nframes * flen; k++) begin
      if (drop && k == flen) enable = 1'b0;
      s_valid = ($urandom % 4) != 0;
      s_data  = 24'($urandom);
      #1;
      check_cycle(k % flen, scen, cur.ok);
      @(negedge clk);
    end
    if (drop) begin
      for (int k = 0; k < 2 * cur.ht + 4; k++) begin
        s_valid = ($urandom % 2) != 0;
        s_data  = 24'($urandom);
        #1;
        check_cycle(0, {scen, " R10 idle"}, 1'b0);
        @(negedge clk);
      end
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got 0 expected 1");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    cur = expect_of(1, 1, 1, 1, 1, 1, 1, 1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(de == 0 && hsync == 0 && vsync == 0 && fetch_pulse == 0 && line_cnt == 0 && s_ready == 0,
          "R9 reset idle", int'({de, hsync, vsync, fetch_pulse, s_ready}), 0);
    @(negedge clk);

    // R6 fetch branches (third: W - sof; second: whole porch; first: none) and R7 pulse
    set_mode(4, 6, 8, 10, 3, 8, 10, 11, 0, 0, 0, 0, 1); play("R6 fetch W-sof", 2, 1, 0);
    set_mode(4, 6, 8, 10, 3, 4, 6, 7,   0, 0, 0, 0, 1); play("R6 fetch whole porch", 1, 1, 0);
    set_mode(4, 6, 8, 10, 3, 5, 8, 11,  0, 0, 0, 0, 1); play("R6 R7 no fetch", 1, 1, 0);
    // R2 negative syncs, R3 DSI override
    set_mode(4, 6, 8, 10, 3, 8, 10, 11, 0, 0, 1, 1, 1); play("R2 negative sync", 1, 1, 0);
    set_mode(4, 6, 8, 10, 3, 8, 10, 11, 0, 1, 1, 1, 1); play("R3 dsi forces high", 1, 1, 0);
    // R4 porch folding
    set_mode(4, 6, 8, 10, 3, 8, 10, 11, 0, 2, 0, 1, 1); play("R4 dp fold", 1, 1, 0);
    set_mode(4, 6, 8, 10, 3, 4, 6, 7,   0, 3, 1, 0, 1); play("R4 edp fold", 1, 1, 0);
    // R8 split halving
    set_mode(8, 12, 16, 20, 3, 8, 10, 11, 1, 0, 0, 0, 1); play("R8 split", 1, 1, 0);
    // R5 rejected geometry
    set_mode(4, 3, 8, 10, 3, 8, 10, 11, 0, 0, 1, 0, 1); play("R5 sync start before active", 1, 1, 0);
    set_mode(4, 6, 8, 10, 3, 8, 7, 11,  0, 0, 0, 1, 1); play("R5 sync end before start", 1, 1, 0);
    set_mode(4, 6, 8, 7,  3, 8, 10, 11, 0, 0, 0, 0, 1); play("R5 total before sync end", 1, 1, 0);
    set_mode(1, 2, 3, 4,  3, 8, 10, 11, 1, 0, 0, 0, 1); play("R5 R8 split to zero", 1, 1, 0);

    // R9 capture: inputs changed while running are ignored, then restart mid-frame
    set_mode(4, 6, 8, 10, 3, 8, 10, 11, 0, 0, 0, 0, 1); play("R9 capture A", 1, 1, 0);
    set_mode(5, 6, 7, 9, 2, 4, 5, 7, 0, 0, 1, 1, 0);    play("R9 inputs ignored", 1, 0, 0);
    repeat (13) @(negedge clk);
    set_mode(5, 6, 7, 9, 2, 4, 5, 7, 0, 0, 1, 1, 1);    play("R9 restart mid-frame", 1, 1, 0);

    // R10 enable dropped at the start of frame two
    set_mode(4, 6, 8, 10, 3, 8, 10, 11, 0, 0, 0, 0, 1); play("R10 finish frame", 2, 1, 1);

    // constrained random modes
    for (int i = 0; i < 30; i++) begin
      int ha, hf, hs, hb, va, vf, vs, vb, hss, hse, htt, vss, vse, vtt;
      ha = 1 + $urandom % 8; hf = $urandom % 4; hs = $urandom % 4; hb = $urandom % 4;
      va = 1 + $urandom % 5; vf = $urandom % 5; vs = $urandom % 4; vb = $urandom % 4;
      hss = ha + hf; hse = hss + hs; htt = hse + hb;
      vss = va + vf; vse = vss + vs; vtt = vse + vb;
      case ($urandom % 10)
        0: hss = ha - 1;
        1: vse = vss - 1;
        2: htt = hse - 1;
        default: ;
      endcase
      set_mode(ha, hss, hse, htt, va, vss, vse, vtt, ($urandom % 4) == 0, int'($urandom % 4),
               bit'($urandom % 2), bit'($urandom % 2), 1);
      play("R1 random", 1 + int'($urandom % 2), 1, 0);
    end

    enable = 1'b0;
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule